// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital side of a 12-bit successive-approximation converter. A conversion request starts a search that tests one result bit per clock, from the most significant bit down. In each step the block presents a trial code to the analog section and samples a one-bit comparator answer. When the last bit has been decided, the result is stored, a ready flag is set and a one-cycle interrupt is raised. A busy output stays high for the whole search.

Software reaches the block through a simple synchronous register bus: one write strobe, one read strobe, a byte address and 32-bit data. Read data returns one cycle after the read strobe. Six registers are mapped: a negative-input channel select, a status word holding the ready flag, the result, a reset trigger, and two 10-bit calibration words for gain and offset. The block only stores the calibration words. It does not apply them to results.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After the synchronous reset, busy and irq are low and trial_code is zero. Status (0x0C) and data (0x10) read 0, gain (0x30) and offset (0x34) read 0x200, and channel select (0x08) reads 0.
- R2: A conv_req sampled while idle raises busy at the next edge, with trial_code = 0x800. For each of the 12 following edges the bit under test is kept only if cmp_in is 1 (input at or above the trial level), and the next lower bit is then set for trial. With a comparator that reports 1 whenever trial_code <= V, the result is V.
- R3: busy stays high for exactly 12 cycles. One cycle after busy falls, status bit 0 (ready) is 1 and data bits 11:0 hold the result. irq is high for exactly that one cycle.
- R4: A read of the data register (0x10) clears the ready flag, so a later status read returns 0.
- R5: A conv_req that arrives while busy is ignored: the running conversion ends on its original schedule and no second conversion follows.
- R6: A write of any value to the reset register (0x14) returns every register to its R1 value and aborts any running conversion. busy and irq are low at the next edge, and no interrupt follows.
- R7: Gain (0x30) and offset (0x34) store wdata bits 9:0. They read back with bits 31:10 equal to zero.
- R8: Channel select (0x08) takes its code from wdata bits 4:0. Codes 0 to 16 are accepted (16 means the internal reference), and codes 17 to 31 are ignored so the old code is kept. Bits 31:5 read as zero, and neg_chan always shows the stored code.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets or to the read-only status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| conv_req | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator answer: 1 when the input is at or above trial_code |
| trial_code | output | 12 | Code presented to the capacitive DAC |
| busy | output | 1 | High while a conversion runs |
| irq | output | 1 | One-cycle pulse when a result is ready |
| neg_chan | output | 5 | Selected negative input channel |

## Verification
The checker assumes that software never issues a read and a write in the same cycle. It also assumes that a reset-register write is the only way software aborts a search. Its timing properties count busy cycles from the rising edge and allow a shorter run only when a reset-register write came just before. The bench drives one bus strobe per access, and its comparator is a pure function of the current trial_code. It issues its single mid-conversion reset write between conversions that run to completion, so every input stays within these assumptions.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned ADC_BITS  = 12;
  localparam int unsigned CAL_BITS  = 10;
  localparam int unsigned CHAN_BITS = 5;
  localparam int unsigned CHAN_TOP  = 16;
  localparam int unsigned BUS_BITS  = 32;
  localparam int unsigned OFS_BITS  = 8;

  localparam logic [OFS_BITS-1:0] A_CHAN   = 8'h08;
  localparam logic [OFS_BITS-1:0] A_STATUS = 8'h0C;
  localparam logic [OFS_BITS-1:0] A_DATA   = 8'h10;
  localparam logic [OFS_BITS-1:0] A_RESET  = 8'h14;
  localparam logic [OFS_BITS-1:0] A_GAIN   = 8'h30;
  localparam logic [OFS_BITS-1:0] A_OFFS   = 8'h34;

  localparam int unsigned CAL_DEFAULT = 32'h200;
endpackage

// File: rtl/sar_adc_engine.sv
module sar_adc_engine #(
  parameter int unsigned RES_W = sar_adc_pkg::ADC_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] probe;
  logic [RES_W-1:0] kept;

  // the bit under test survives only when the comparator says input >= trial
  always_comb begin
    kept = cmp_in ? trial : (trial & ~probe);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      probe  <= '0;
      trial  <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          probe <= TOP_BIT;
          trial <= TOP_BIT;
        end
      end else begin
        probe <= probe >> 1;
        trial <= kept | (probe >> 1);
        if (probe[0]) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= kept;
        end
      end
    end
  end
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs #(
  parameter int unsigned RES_W  = sar_adc_pkg::ADC_BITS,
  parameter int unsigned CAL_W  = sar_adc_pkg::CAL_BITS,
  parameter int unsigned CH_W   = sar_adc_pkg::CHAN_BITS,
  parameter int unsigned CH_MAX = sar_adc_pkg::CHAN_TOP,
  parameter int unsigned DATA_W = sar_adc_pkg::BUS_BITS,
  parameter int unsigned ADDR_W = sar_adc_pkg::OFS_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_result,
  output logic              soft_clr,
  output logic [CH_W-1:0]   neg_chan,
  output logic              irq
);
  import sar_adc_pkg::*;

  localparam logic [CH_W-1:0]  CH_LAST = CH_W'(CH_MAX);
  localparam logic [CAL_W-1:0] CAL_MID = CAL_W'(CAL_DEFAULT);

  logic              ready_q;
  logic [RES_W-1:0]  data_q;
  logic [CAL_W-1:0]  gain_q;
  logic [CAL_W-1:0]  offs_q;
  logic [CH_W-1:0]   chan_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_chan, wr_gain, wr_offs, rd_data;
  logic              code_ok;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CAL_W];

  always_comb begin
    soft_clr = bus_wr && (bus_addr == A_RESET);
    wr_chan  = bus_wr && (bus_addr == A_CHAN);
    wr_gain  = bus_wr && (bus_addr == A_GAIN);
    wr_offs  = bus_wr && (bus_addr == A_OFFS);
    rd_data  = bus_rd && (bus_addr == A_DATA);
    code_ok  = bus_wdata[CH_W-1:0] <= CH_LAST;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ready_q <= 1'b0;
      irq     <= 1'b0;
      data_q  <= '0;
      gain_q  <= CAL_MID;
      offs_q  <= CAL_MID;
      chan_q  <= '0;
    end else begin
      irq <= eng_done;
      // a finishing conversion wins over a same-cycle data read
      if (eng_done) begin
        ready_q <= 1'b1;
        data_q  <= eng_result;
      end else if (rd_data) begin
        ready_q <= 1'b0;
      end
      if (wr_chan && code_ok) chan_q <= bus_wdata[CH_W-1:0];
      if (wr_gain)            gain_q <= bus_wdata[CAL_W-1:0];
      if (wr_offs)            offs_q <= bus_wdata[CAL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CHAN:   rd_mux = DATA_W'(chan_q);
      A_STATUS: rd_mux = DATA_W'(ready_q);
      A_DATA:   rd_mux = DATA_W'(data_q);
      A_GAIN:   rd_mux = DATA_W'(gain_q);
      A_OFFS:   rd_mux = DATA_W'(offs_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign neg_chan = chan_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned RES_W  = sar_adc_pkg::ADC_BITS,
  parameter int unsigned CAL_W  = sar_adc_pkg::CAL_BITS,
  parameter int unsigned CH_W   = sar_adc_pkg::CHAN_BITS,
  parameter int unsigned CH_MAX = sar_adc_pkg::CHAN_TOP,
  parameter int unsigned DATA_W = sar_adc_pkg::BUS_BITS,
  parameter int unsigned ADDR_W = sar_adc_pkg::OFS_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              conv_req,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  trial_code,
  output logic              busy,
  output logic              irq,
  output logic [CH_W-1:0]   neg_chan
);
  logic             soft_clr;
  logic             eng_done;
  logic [RES_W-1:0] eng_result;

  sar_adc_engine #(.RES_W(RES_W)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .abort  (soft_clr),
    .start  (conv_req),
    .cmp_in (cmp_in),
    .trial  (trial_code),
    .busy   (busy),
    .done   (eng_done),
    .result (eng_result)
  );

  sar_adc_regs #(
    .RES_W(RES_W), .CAL_W(CAL_W), .CH_W(CH_W), .CH_MAX(CH_MAX),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_done   (eng_done),
    .eng_result (eng_result),
    .soft_clr   (soft_clr),
    .neg_chan   (neg_chan),
    .irq        (irq)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned RES_W  = sar_adc_pkg::ADC_BITS,
  parameter int unsigned CH_W   = sar_adc_pkg::CHAN_BITS,
  parameter int unsigned CH_MAX = sar_adc_pkg::CHAN_TOP,
  parameter int unsigned ADDR_W = sar_adc_pkg::OFS_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [RES_W-1:0]  trial_code,
  input logic              busy,
  input logic              irq,
  input logic [CH_W-1:0]   neg_chan
);
  localparam int unsigned CW = $clog2(RES_W) + 1;

  logic          sw_hit;
  logic [CW-1:0] run_len;

  assign sw_hit = bus_wr && (bus_addr == sar_adc_pkg::A_RESET);

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R2: a new search starts with only the top bit set
  p_first_trial_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> trial_code == {1'b1, {(RES_W-1){1'b0}}});

  // R3: busy never lasts past RES_W cycles
  p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < CW'(RES_W));

  // R3, R5: an unaborted search lasts exactly RES_W cycles
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(sw_hit) |-> $past(run_len) == CW'(RES_W - 1));

  // R3: end of search is followed by the interrupt
  p_irq_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(sw_hit) && !sw_hit |=> irq);

  // R3: interrupt is a single-cycle pulse
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6: reset-register write leaves the block idle and quiet
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    sw_hit |=> !busy && !irq && neg_chan == '0);

  // R8: stored channel code never leaves the legal range
  p_chan_legal_r8: assert property (@(posedge clk) disable iff (rst)
    neg_chan <= CH_W'(CH_MAX));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .CH_MAX(CH_MAX), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .trial_code (trial_code),
  .busy       (busy),
  .irq        (irq),
  .neg_chan   (neg_chan)
);

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        conv_req = 1'b0;
  logic        cmp_in;
  logic [11:0] trial_code;
  logic        busy;
  logic        irq;
  logic [4:0]  neg_chan;
  logic [11:0] vin = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  // ideal comparator: input at or above the trial level
  assign cmp_in = (trial_code <= vin);

  sar_adc_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_req(conv_req), .cmp_in(cmp_in), .trial_code(trial_code),
    .busy(busy), .irq(irq), .neg_chan(neg_chan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: compare returned read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected read data actual=0x%0h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      finish_run();
    end
  end

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // poke: cycle index (1..11) at which a second request is raised, 0 for none
  task automatic run_conv(input logic [11:0] v, input int poke);
    vin = v;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    chk("R2 busy rises", 32'(busy), 32'd1);
    chk("R2 first trial", 32'(trial_code), 32'h800);
    for (int i = 1; i <= 11; i++) begin
      if (i == poke) conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
    end
    chk("R3 busy on last step", 32'(busy), 32'd1);
    @(negedge clk);
    chk(poke != 0 ? "R5 busy ends on schedule" : "R3 busy ends", 32'(busy), 32'd0);
    chk("R3 irq waits a cycle", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R3 irq pulse", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R3 irq one cycle", 32'(irq), 32'd0);
    if (poke != 0) chk("R5 no second search", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 trial", 32'(trial_code), 32'd0);
    chk("R1 neg_chan", 32'(neg_chan), 32'd0);
    bus_read(8'h0C, 32'd0, "R1 status");
    bus_read(8'h10, 32'd0, "R1 data");
    bus_read(8'h30, 32'h200, "R1 gain");
    bus_read(8'h34, 32'h200, "R1 offset");
    bus_read(8'h08, 32'd0, "R1 channel");

    // R2/R3/R4 conversions over several input levels
    run_conv(12'hA5C, 0);
    bus_read(8'h0C, 32'd1, "R3 ready set");
    bus_read(8'h10, 32'hA5C, "R2 result A5C");
    bus_read(8'h0C, 32'd0, "R4 ready cleared");
    bus_read(8'h10, 32'hA5C, "R4 data kept");
    run_conv(12'h000, 0);
    bus_read(8'h10, 32'h000, "R2 result zero");
    run_conv(12'hFFF, 0);
    bus_read(8'h10, 32'hFFF, "R2 result full");
    run_conv(12'h800, 0);
    bus_read(8'h10, 32'h800, "R2 result mid");
    run_conv(12'h001, 0);
    bus_read(8'h10, 32'h001, "R2 result one");

    // R5 request while busy is ignored
    run_conv(12'h3C7, 5);
    bus_read(8'h10, 32'h3C7, "R5 result intact");

    // R7 calibration words
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_read(8'h30, 32'h3FF, "R7 gain width");
    bus_write(8'h34, 32'h0000_0155);
    bus_read(8'h34, 32'h155, "R7 offset store");

    // R8 channel select
    bus_write(8'h08, 32'd16);
    bus_read(8'h08, 32'd16, "R8 internal ref code");
    chk("R8 neg_chan 16", 32'(neg_chan), 32'd16);
    bus_write(8'h08, 32'd17);
    bus_read(8'h08, 32'd16, "R8 code 17 ignored");
    bus_write(8'h08, 32'd31);
    chk("R8 code 31 ignored", 32'(neg_chan), 32'd16);
    bus_write(8'h08, 32'h0000_00E5);
    bus_read(8'h08, 32'd5, "R8 upper bits dropped");
    chk("R8 neg_chan 5", 32'(neg_chan), 32'd5);

    // R9 unmapped and read-only
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, 32'd0, "R9 unmapped read");
    bus_write(8'h0C, 32'd1);
    bus_read(8'h0C, 32'd0, "R9 status read-only");
    bus_read(8'h08, 32'd5, "R9 unmapped write harmless");

    // R6 reset register aborts and restores defaults
    vin = 12'h5A5;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    repeat (3) @(negedge clk);
    bus_write(8'h14, 32'h0);
    chk("R6 busy dropped", 32'(busy), 32'd0);
    chk("R6 neg_chan default", 32'(neg_chan), 32'd0);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (irq !== 1'b0) chk("R6 no irq after abort", 32'(irq), 32'd0);
    end
    chk("R6 still idle", 32'(busy), 32'd0);
    bus_read(8'h0C, 32'd0, "R6 status default");
    bus_read(8'h10, 32'd0, "R6 data default");
    bus_read(8'h30, 32'h200, "R6 gain default");
    bus_read(8'h34, 32'h200, "R6 offset default");
    bus_read(8'h08, 32'd0, "R6 channel default");

    // block works again after the abort
    run_conv(12'h7FF, 0);
    bus_read(8'h10, 32'h7FF, "R6 conversion after reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R9 pending reads", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule